// File: doc/BRIEF.md
# Fast-to-slow register value synchronizer

This block carries a multi-bit configuration word from a fast bus clock domain into a much slower counter clock domain. The writer on the fast side may change the word on any fast cycle and gives no notice. The slow side must never register a word while its bits are changing.

The fast side keeps a held copy of the input word. It also samples the slow clock and turns each slow rising edge into a single-cycle pulse. A safe flag records that the slow side has taken the last held copy. When the flag is set, the held copy is reloaded in the fast cycle right after a detected slow edge, and a request toggle is flipped. The toggle crosses into the slow domain through a synchronizer. When the slow side sees it change, it registers the held copy onto its output. The toggle's own change, seen in the fast domain, produces a one-cycle pulse that drops the safe flag. The flag rises again only when the slow side's acknowledge has come back through a second synchronizer.

Place the block wherever a fast-written setting, such as a counter reload value, must be read by logic on a slow clock.

Top module: `cdc_word_hold`

## Requirements
- R1: While reset is low, and for at least one slow period after it is released, `word_out` equals the parameter `RST_WORD` (default 16'hA5C3), whatever `word_in` holds.
- R2: When `word_in` is held constant, `word_out` equals it within 12 slow periods, for any slow-to-fast period ratio from 4:1 to 16:1.
- R3: Every value `word_out` takes is either `RST_WORD` or a value that `word_in` held at some fast clock edge, even when `word_in` changes on every fast cycle. The value is never a mix of bits from two inputs.
- R4: After `word_out` changes at a slow rising edge, it stays unchanged across at least the next two slow rising edges.
- R5: While `word_in` changes on every fast cycle, `word_out` still updates at least three times within 60 slow periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast bus clock; `word_in` belongs to this domain |
| clk_slow | input | 1 | Slow counter clock; `word_out` belongs to this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| word_in | input | W | Configuration word, may change on any fast cycle |
| word_out | output | W | Stable copy registered on `clk_slow` |

## Verification
The main function is first tried with single steady words: all zeros, all ones, alternating bit patterns, and the reset value itself. Each word is applied under a different clock ratio between 4:1 and 16:1, which shows that delivery does not depend on the phase relation of the clocks. A second pattern changes the input word randomly on every fast cycle. Here a word built from two inputs would show up as a value that was never driven, and a handshake that stalls would show up as too few updates. A reset in the middle of the run, with a pending non-reset input, shows that the reset value wins and that no stale transfer completes right after release.

// File: rtl/cdc_hold_pkg.sv
package cdc_hold_pkg;

    localparam int MIN_SYNC_STAGES = 2;

    function automatic int clamp_stages(input int n);
        return (n < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : n;
    endfunction

    function automatic logic flip_seen(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync
    import cdc_hold_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int N = clamp_stages(STAGES);

    logic [N-1:0] chain_d;
    logic [N-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[N-1];

endmodule

// File: rtl/cdc_hold_fast.sv
module cdc_hold_fast
    import cdc_hold_pkg::*;
#(
    parameter int             W           = 16,
    parameter logic [W-1:0]   RST_WORD    = '0,
    parameter int             SYNC_STAGES = 2
) (
    input  logic         clk_fast,
    input  logic         rst_n,
    input  logic         clk_slow_raw,
    input  logic         ack_raw,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] hold_word,
    output logic         req_tgl,
    output logic         safe,
    output logic         slow_rise
);

    typedef struct packed {
        logic [W-1:0] hold;
        logic         safe;
        logic         tgl;
        logic         tgl_prev;
        logic         sclk_prev;
    } fast_st_t;

    localparam fast_st_t FAST_RST = '{
        hold:      RST_WORD,
        safe:      1'b1,
        tgl:       1'b0,
        tgl_prev:  1'b0,
        sclk_prev: 1'b0
    };

    fast_st_t st_d;
    fast_st_t st_q;

    logic sclk_s;
    logic ack_s;
    logic rise;
    logic clr_pulse;
    logic idle;
    logic load;

    cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .din   (clk_slow_raw),
        .dout  (sclk_s)
    );

    cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .din   (ack_raw),
        .dout  (ack_s)
    );

    assign rise      = sclk_s & ~st_q.sclk_prev;
    assign clr_pulse = flip_seen(st_q.tgl, st_q.tgl_prev);
    assign idle      = ~flip_seen(ack_s, st_q.tgl);
    assign load      = rise & st_q.safe & idle;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.tgl_prev  = st_q.tgl;
        if (load) begin
            st_d.hold = word_in;
            st_d.tgl  = ~st_q.tgl;
        end
        if (clr_pulse) begin
            st_d.safe = 1'b0;
        end else if (!st_q.safe && idle) begin
            st_d.safe = 1'b1;
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= FAST_RST;
        else        st_q <= st_d;
    end

    assign hold_word = st_q.hold;
    assign req_tgl   = st_q.tgl;
    assign safe      = st_q.safe;
    assign slow_rise = rise;

endmodule

// File: rtl/cdc_hold_slow.sv
module cdc_hold_slow
    import cdc_hold_pkg::*;
#(
    parameter int             W           = 16,
    parameter logic [W-1:0]   RST_WORD    = '0,
    parameter int             SYNC_STAGES = 2
) (
    input  logic         clk_slow,
    input  logic         rst_n,
    input  logic         req_raw,
    input  logic [W-1:0] hold_word,
    output logic [W-1:0] word_out,
    output logic         ack
);

    typedef struct packed {
        logic [W-1:0] out;
        logic         seen;
    } slow_st_t;

    localparam slow_st_t SLOW_RST = '{out: RST_WORD, seen: 1'b0};

    slow_st_t st_d;
    slow_st_t st_q;

    logic req_s;

    cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .din   (req_raw),
        .dout  (req_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.seen = req_s;
        if (flip_seen(req_s, st_q.seen)) begin
            st_d.out = hold_word;
        end
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) st_q <= SLOW_RST;
        else        st_q <= st_d;
    end

    assign word_out = st_q.out;
    assign ack      = st_q.seen;

endmodule

// File: rtl/cdc_word_hold.sv
module cdc_word_hold #(
    parameter int             W           = 16,
    parameter logic [W-1:0]   RST_WORD    = 16'hA5C3,
    parameter int             SYNC_STAGES = 2
) (
    input  logic         clk_fast,
    input  logic         clk_slow,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);

    logic [W-1:0] hold_word;
    logic         req_tgl;
    logic         ack_tgl;
    logic         safe;
    logic         slow_rise;

    cdc_hold_fast #(
        .W           (W),
        .RST_WORD    (RST_WORD),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fast (
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .clk_slow_raw (clk_slow),
        .ack_raw      (ack_tgl),
        .word_in      (word_in),
        .hold_word    (hold_word),
        .req_tgl      (req_tgl),
        .safe         (safe),
        .slow_rise    (slow_rise)
    );

    cdc_hold_slow #(
        .W           (W),
        .RST_WORD    (RST_WORD),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slow (
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .req_raw   (req_tgl),
        .hold_word (hold_word),
        .word_out  (word_out),
        .ack       (ack_tgl)
    );

endmodule

// File: rtl/cdc_word_hold_chk.sv
module cdc_word_hold_chk #(
    parameter int W = 16
) (
    input logic         clk_fast,
    input logic         clk_slow,
    input logic         rst_n,
    input logic [W-1:0] hold_word,
    input logic         req_tgl,
    input logic         safe,
    input logic         slow_rise,
    input logic [W-1:0] word_out
);

    AST_HOLD_ON_EDGE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (hold_word != $past(hold_word)) |-> $past(slow_rise)); // R3

    AST_HOLD_WHEN_SAFE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (hold_word != $past(hold_word)) |-> $past(safe)); // R3

    AST_RISE_SINGLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        slow_rise |=> !slow_rise); // R5

    AST_SAFE_DROP: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (req_tgl != $past(req_tgl)) |=> !safe); // R4

    AST_OUT_FROM_HOLD: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (word_out != $past(word_out)) |-> (word_out == hold_word)); // R3

    AST_OUT_HOLD_ONE: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (word_out != $past(word_out)) |=> $stable(word_out)); // R4

    AST_OUT_HOLD_TWO: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (word_out != $past(word_out)) |=> ##1 $stable(word_out)); // R4

endmodule

bind cdc_word_hold cdc_word_hold_chk #(.W(W)) u_chk (
    .clk_fast  (clk_fast),
    .clk_slow  (clk_slow),
    .rst_n     (rst_n),
    .hold_word (hold_word),
    .req_tgl   (req_tgl),
    .safe      (safe),
    .slow_rise (slow_rise),
    .word_out  (word_out)
);

// File: tb/cdc_word_hold_tb.sv
module cdc_word_hold_tb;

    localparam int           CLK_PERIOD = 10;
    localparam int           W          = 16;
    localparam logic [W-1:0] RST_WORD   = 16'hA5C3;
    localparam int           NVEC       = 8;

    localparam logic [W-1:0] VEC_WORD [NVEC] = '{
        16'h1234, 16'h0000, 16'hFFFF, 16'h5555,
        16'hAAAA, 16'hA5C3, 16'h8001, 16'h7FFE
    };
    localparam int VEC_RATIO [NVEC] = '{4, 5, 7, 4, 11, 16, 6, 4};

    logic         clk_fast = 1'b0;
    logic         clk_slow = 1'b0;
    logic         rst_n    = 1'b0;
    logic [W-1:0] word_in  = 16'h1234;
    logic [W-1:0] word_out;

    int slow_half = 2 * CLK_PERIOD;
    int checks    = 0;
    int errors    = 0;
    bit done      = 1'b0;

    bit           seen_vals [logic [W-1:0]];
    bit           mon_en    = 1'b0;
    bit           have_last = 1'b0;
    logic [W-1:0] last_out  = RST_WORD;
    int           run       = 0;
    int           n_changes = 0;

    cdc_word_hold #(.W(W), .RST_WORD(RST_WORD)) u_dut (
        .clk_fast (clk_fast),
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .word_in  (word_in),
        .word_out (word_out)
    );

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

    initial begin
        #2;
        forever #(slow_half) clk_slow = ~clk_slow;
    end

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic drive(input logic [W-1:0] v);
        @(negedge clk_fast);
        word_in      = v;
        seen_vals[v] = 1'b1;
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(negedge clk_slow);
    endtask

    task automatic set_ratio(input int r);
        slow_half = r * CLK_PERIOD / 2;
    endtask

    // slow-domain monitor: R3 membership, R4 spacing, R5 update count
    always @(negedge clk_slow) begin
        if (mon_en) begin
            if (word_out !== last_out) begin
                check(seen_vals.exists(word_out), "R3 undriven word", word_out, last_out);
                if (have_last)
                    check(run >= 2, "R4 spacing", 16'(run), 16'd2);
                n_changes++;
                have_last = 1'b1;
                last_out  = word_out;
                run       = 0;
            end else begin
                run++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk_fast);
        errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        seen_vals[RST_WORD] = 1'b1;
        seen_vals[word_in]  = 1'b1;

        // R1: reset value while reset is held, input differs
        repeat (5) @(negedge clk_fast);
        check(word_out == RST_WORD, "R1 in reset", word_out, RST_WORD);
        @(negedge clk_fast);
        rst_n = 1'b1;
        @(negedge clk_fast);
        check(word_out == RST_WORD, "R1 at release", word_out, RST_WORD);
        wait_slow(1);
        check(word_out == RST_WORD, "R1 one slow period", word_out, RST_WORD);
        last_out = word_out;
        mon_en   = 1'b1;

        // R2: steady words under various ratios
        for (int i = 0; i < NVEC; i++) begin
            set_ratio(VEC_RATIO[i]);
            drive(VEC_WORD[i]);
            wait_slow(12);
            check(word_out == VEC_WORD[i], "R2 steady word", word_out, VEC_WORD[i]);
        end

        // R3/R4/R5: input changes on every fast cycle
        for (int k = 0; k < 3; k++) begin
            int r;
            int c0;
            r  = (k == 0) ? 4 : ((k == 1) ? 9 : 16);
            set_ratio(r);
            wait_slow(2);
            c0 = n_changes;
            repeat (60 * r) drive(16'($urandom));
            check((n_changes - c0) >= 3, "R5 updates under churn",
                  16'(n_changes - c0), 16'd3);
            drive(16'h3C3C + 16'(k));
            wait_slow(12);
            check(word_out == 16'h3C3C + 16'(k), "R2 after churn",
                  word_out, 16'h3C3C + 16'(k));
        end

        // R1: reset in mid run with a pending different input
        set_ratio(5);
        mon_en = 1'b0;
        drive(16'h0F0F);
        @(negedge clk_fast);
        rst_n = 1'b0;
        repeat (3) @(negedge clk_fast);
        check(word_out == RST_WORD, "R1 mid-run reset", word_out, RST_WORD);
        rst_n = 1'b1;
        wait_slow(1);
        check(word_out == RST_WORD, "R1 after mid-run release", word_out, RST_WORD);
        have_last = 1'b0;
        last_out  = word_out;
        mon_en    = 1'b1;
        wait_slow(12);
        check(word_out == 16'h0F0F, "R2 after mid-run reset", word_out, 16'h0F0F);

        finish_run();
    end

endmodule